// File: doc/BRIEF.md
# Sync Source Router with Adaptive Vertical Separator

This block sits behind the analog front end of a multiscan display controller. It receives three sync streams that have already been sliced and normalized to active-high logic, and a presence flag for each: a composite-or-horizontal sync, a sync recovered from the video signal, and a separate vertical sync. It produces two active-high drive outputs, a horizontal drive and a vertical drive. All inputs are synchronous to `clk`.

The horizontal drive is taken from one source, chosen by a fixed priority. The vertical drive uses the separate vertical input when that input is present. Otherwise the block separates vertical timing out of the chosen horizontal source. For this it measures the line period between leading edges and marks a pulse as vertical once the pulse is wider than half of that period. Because the threshold follows the measured line rate, a vertical pulse as short as one line is caught at any horizontal frequency. A control input sets whether the horizontal pulses that fall inside the vertical interval are kept on the horizontal drive or blanked.

The separator is a three-state machine:
- `VS_UNLOCKED`: no trusted line period yet.
- `VS_SEARCH`: waiting for an over-width pulse.
- `VS_ACTIVE`: the vertical drive is asserted.

Its transitions are:
- lock gained (`VS_UNLOCKED` to `VS_SEARCH`)
- over-width seen (`VS_SEARCH` to `VS_ACTIVE`)
- narrow pulse ended (`VS_ACTIVE` to `VS_SEARCH`)
- lock lost (any state to `VS_UNLOCKED`)

Lock is lost when the selected source changes or disappears.

Top module: `sync_router`

## Requirements
- R1: When `csync_present_i` is 1, `hdrv_o` follows `csync_i` two clock cycles later, whatever the video sync does.
- R2: When `csync_present_i` is 0 and `vid_present_i` is 1, `hdrv_o` follows `vidsync_i` two cycles later, whatever `csync_i` does.
- R3: When both `csync_present_i` and `vid_present_i` are 0, `hdrv_o` stays 0.
- R4: When `vsync_present_i` is 1, `vdrv_o` equals `vsync_i` from two cycles earlier, and over-width pulses on the horizontal source have no effect on it.
- R5: With no separate vertical sync, a pulse on the composite source wider than half the tracked line period drives `vdrv_o` to 1 while that pulse is still high.
- R6: Once asserted, the separated vertical drive stays 1 through the leading normal-width pulse that follows the over-width ones, and returns to 0 after that pulse ends.
- R7: A single over-width line (a vertical pulse of one line) is separated.
- R8: The line period is the cycle count between leading edges of the selected source. After a rate change, a new value is taken once two consecutive periods agree within 1/8, so the width threshold follows the new rate.
- R9: An isolated period that differs from the tracked period by more than 1/8 is not taken, and the threshold keeps its old value.
- R10: When `keep_vint_i` is 1, `hdrv_o` carries the source pulses while `vdrv_o` is 1.
- R11: When `keep_vint_i` was 0 in the previous cycle, `hdrv_o` and `vdrv_o` are never 1 together.
- R12: During reset both outputs are 0.
- R13: With composite sync absent, vertical timing is separated from the video sync in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_i | input | 1 | Normalized composite or horizontal sync, active high |
| csync_present_i | input | 1 | Composite/horizontal sync is present |
| vidsync_i | input | 1 | Sync sliced from video, active high |
| vid_present_i | input | 1 | Video sync is present |
| vsync_i | input | 1 | Normalized separate vertical sync, active high |
| vsync_present_i | input | 1 | Separate vertical sync is present |
| keep_vint_i | input | 1 | 1 keeps horizontal pulses during the vertical interval; 0 blanks them |
| hdrv_o | output | 1 | Horizontal drive, active high |
| vdrv_o | output | 1 | Vertical drive, active high |

## Verification
On every cycle, the assertions check the source routing (R1 to R3), the pass-through of the separate vertical sync (R4), and the ban on horizontal drive during the vertical interval when blanking is selected (R11). These relations are simple cycle-exact functions of the ports. Separation depends on a period learned over several lines, so only the bench scenarios can show it:
- over-width detection (R5, R7, R13)
- release after the trailing narrow pulse (R6)
- adaptation to a new line rate (R8)
- rejection of an outlier period (R9)

The bench checks each of these at mid-pulse points, where the threshold margins make the expected value unambiguous.

// File: rtl/sync_router_pkg.sv
package sync_router_pkg;

    typedef enum logic [1:0] {
        HSRC_NONE,
        HSRC_COMP,
        HSRC_VIDEO
    } hsrc_e;

    typedef enum logic [1:0] {
        VS_UNLOCKED,
        VS_SEARCH,
        VS_ACTIVE
    } vsep_state_e;

endpackage

// File: rtl/sr_line_tracker.sv
module sr_line_tracker #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rise,
    output logic [CNT_W-1:0] period_o,
    output logic             valid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] lcnt;
    logic [CNT_W-1:0] prev_cand;
    logic             near_trk;
    logic             near_prev;

    function automatic logic within_eighth(input logic [CNT_W-1:0] a,
                                           input logic [CNT_W-1:0] ref_v);
        logic [CNT_W-1:0] diff;
        diff = (a >= ref_v) ? (a - ref_v) : (ref_v - a);
        return (ref_v != '0) && (diff <= (ref_v >> 3));
    endfunction

    always_comb begin
        near_trk  = valid_o && within_eighth(lcnt, period_o);
        near_prev = within_eighth(lcnt, prev_cand);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcnt      <= '0;
            prev_cand <= '0;
            period_o  <= '0;
            valid_o   <= 1'b0;
        end else if (clr) begin
            lcnt      <= '0;
            prev_cand <= '0;
            period_o  <= '0;
            valid_o   <= 1'b0;
        end else if (rise) begin
            lcnt      <= {{(CNT_W-1){1'b0}}, 1'b1};
            prev_cand <= lcnt;
            if (near_trk || near_prev) begin
                period_o <= lcnt;
                valid_o  <= 1'b1;
            end
        end else if (lcnt != CNT_MAX) begin
            lcnt <= lcnt + 1'b1;
        end
    end

endmodule

// File: rtl/sr_vsep_fsm.sv
module sr_vsep_fsm
    import sync_router_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src,
    input  logic             rise,
    input  logic             fall,
    input  logic [CNT_W-1:0] period,
    input  logic             period_valid,
    output logic             active_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    vsep_state_e      state_q, state_d;
    logic [CNT_W-1:0] wcnt;
    logic [CNT_W-1:0] half_per;
    logic             over_width;

    assign half_per   = period >> 1;
    assign over_width = wcnt > half_per;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (rise) begin
            wcnt <= {{(CNT_W-1){1'b0}}, 1'b1};
        end else if (src && wcnt != CNT_MAX) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!period_valid) begin
            state_d = VS_UNLOCKED;
        end else begin
            unique case (state_q)
                VS_UNLOCKED: state_d = VS_SEARCH;
                VS_SEARCH:   if (src && over_width) state_d = VS_ACTIVE;
                VS_ACTIVE:   if (fall && !over_width) state_d = VS_SEARCH;
                default:     state_d = VS_UNLOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VS_UNLOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        active_o = (state_q == VS_ACTIVE);
    end

endmodule

// File: rtl/sync_router.sv
module sync_router
    import sync_router_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_i,
    input  logic csync_present_i,
    input  logic vidsync_i,
    input  logic vid_present_i,
    input  logic vsync_i,
    input  logic vsync_present_i,
    input  logic keep_vint_i,
    output logic hdrv_o,
    output logic vdrv_o
);
    hsrc_e            sel, sel_q;
    logic             src;
    logic             s0, s1, vs0;
    logic             rise, fall, clr;
    logic [CNT_W-1:0] period;
    logic             period_valid;
    logic             sep_active;
    logic             vint;

    always_comb begin
        if (csync_present_i)    sel = HSRC_COMP;
        else if (vid_present_i) sel = HSRC_VIDEO;
        else                    sel = HSRC_NONE;
    end

    always_comb begin
        unique case (sel)
            HSRC_COMP:  src = csync_i;
            HSRC_VIDEO: src = vidsync_i;
            default:    src = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= HSRC_NONE;
            s0    <= 1'b0;
            s1    <= 1'b0;
            vs0   <= 1'b0;
        end else begin
            sel_q <= sel;
            s0    <= src;
            s1    <= s0;
            vs0   <= vsync_i;
        end
    end

    assign rise = s0 & ~s1;
    assign fall = ~s0 & s1;
    assign clr  = (sel != sel_q) || (sel == HSRC_NONE);

    sr_line_tracker #(.CNT_W(CNT_W)) tracker_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .rise     (rise),
        .period_o (period),
        .valid_o  (period_valid)
    );

    sr_vsep_fsm #(.CNT_W(CNT_W)) vsep_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .src          (s0),
        .rise         (rise),
        .fall         (fall),
        .period       (period),
        .period_valid (period_valid),
        .active_o     (sep_active)
    );

    assign vint = vsync_present_i ? vs0 : sep_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdrv_o <= 1'b0;
            vdrv_o <= 1'b0;
        end else begin
            hdrv_o <= s0 & (keep_vint_i | ~vint);
            vdrv_o <= vint;
        end
    end

endmodule

// File: rtl/sync_router_chk.sv
module sync_router_chk (
    input logic clk,
    input logic rst_n,
    input logic csync_i,
    input logic csync_present_i,
    input logic vidsync_i,
    input logic vid_present_i,
    input logic vsync_i,
    input logic vsync_present_i,
    input logic keep_vint_i,
    input logic hdrv_o,
    input logic vdrv_o
);
    logic [1:0] since_rst;
    logic       hist_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end
    assign hist_ok = (since_rst == 2'd2);

    AST_HDRV_FROM_COMP: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && hdrv_o && $past(csync_present_i, 2) |-> $past(csync_i, 2)); // R1

    AST_HDRV_FROM_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && hdrv_o && !$past(csync_present_i, 2) |-> $past(vidsync_i, 2)); // R2

    AST_HDRV_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && !$past(csync_present_i, 2) && !$past(vid_present_i, 2) |-> !hdrv_o); // R3

    AST_VDRV_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && $past(vsync_present_i) |-> (vdrv_o == $past(vsync_i, 2))); // R4

    AST_HDRV_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok && hdrv_o && vdrv_o |-> $past(keep_vint_i)); // R11

endmodule

bind sync_router sync_router_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .csync_i         (csync_i),
    .csync_present_i (csync_present_i),
    .vidsync_i       (vidsync_i),
    .vid_present_i   (vid_present_i),
    .vsync_i         (vsync_i),
    .vsync_present_i (vsync_present_i),
    .keep_vint_i     (keep_vint_i),
    .hdrv_o          (hdrv_o),
    .vdrv_o          (vdrv_o)
);

// File: tb/sync_router_tb_top.sv
module sync_router_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync = 1'b0, csp = 1'b0, vids = 1'b0, vp = 1'b0;
    logic vsync = 1'b0, vsp = 1'b0, keep = 1'b1;
    logic hdrv, vdrv;

    int cyc = 0;
    int total = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        int    when;
        bit    chk_h;
        bit    exp_h;
        bit    chk_v;
        bit    exp_v;
        string req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sync_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .csync_i(csync), .csync_present_i(csp),
        .vidsync_i(vids), .vid_present_i(vp),
        .vsync_i(vsync), .vsync_present_i(vsp),
        .keep_vint_i(keep),
        .hdrv_o(hdrv), .vdrv_o(vdrv)
    );

    task automatic check(input string req, input string name, input bit act, input bit exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s=%0b expected %0b (cycle %0d)", req, name, act, exp, cyc);
        end
    endtask

    // monitor: pops scoreboard items whose cycle has come
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].when <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            if (it.when < cyc) begin
                total++; fails++;
                $display("FAIL %s: item missed act=none expected cycle %0d", it.req, it.when);
            end else begin
                if (it.chk_h) check(it.req, "hdrv", hdrv, it.exp_h);
                if (it.chk_v) check(it.req, "vdrv", vdrv, it.exp_v);
            end
        end
    end

    // driver: one line on the chosen input; optional expectation at one offset
    // chk: 0 none, 1 hdrv, 2 vdrv, 3 both
    task automatic line(input int len, input int width, input bit on_vid,
                        input int off, input int chk, input bit eh, input bit ev,
                        input string req);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (on_vid) vids = (i < width);
            else        csync = (i < width);
            if (i == off) begin
                exp_t it;
                it.when  = cyc + 2;
                it.chk_h = (chk == 1) || (chk == 3);
                it.chk_v = (chk >= 2);
                it.exp_h = eh;
                it.exp_v = ev;
                it.req   = req;
                sb.push_back(it);
            end
        end
    endtask

    task automatic plain(input int n, input int len, input int width, input bit on_vid);
        for (int k = 0; k < n; k++) line(len, width, on_vid, -1, 0, 0, 0, "");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: done=0 expected 1");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R12", "hdrv", hdrv, 1'b0);
        check("R12", "vdrv", vdrv, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // R1: composite has priority over a present video sync held high
        csp = 1; vp = 1; vids = 1;
        plain(3, 64, 8, 0);
        line(64, 8, 0, 4, 1, 1, 0, "R1");
        line(64, 8, 0, 30, 1, 0, 0, "R1");

        // R2: video fallback, composite input held high and ignored
        csp = 0; csync = 1;
        plain(4, 64, 8, 1);
        line(64, 8, 1, 4, 1, 1, 0, "R2");
        line(64, 8, 1, 30, 1, 0, 0, "R2");

        // R13: vertical separated from video sync
        keep = 1;
        line(64, 56, 1, 50, 2, 0, 1, "R13");
        line(64, 8, 1, -1, 0, 0, 0, "");
        line(64, 8, 1, 40, 2, 0, 0, "R13");

        // R3: no source at all
        vp = 0;
        plain(1, 64, 8, 1);
        line(64, 8, 0, 4, 3, 0, 0, "R3");

        // R5 R6 R10: composite vertical interval, pulses kept on hdrv
        csp = 1; keep = 1;
        plain(6, 64, 8, 0);
        line(64, 24, 0, 30, 2, 0, 0, "R8");   // 24 < 64/2: not vertical at this rate
        line(64, 56, 0, 50, 2, 0, 1, "R5");
        line(64, 56, 0, 50, 3, 1, 1, "R10");
        line(64, 56, 0, -1, 0, 0, 0, "");
        line(64, 8, 0, 4, 2, 0, 1, "R6");     // still active during first narrow pulse
        line(64, 8, 0, 30, 2, 0, 0, "R6");

        // R11: blanked vertical interval
        keep = 0;
        line(64, 8, 0, 4, 1, 1, 0, "R11");
        line(64, 56, 0, 50, 3, 0, 1, "R11");
        line(64, 56, 0, -1, 0, 0, 0, "");
        line(64, 8, 0, -1, 0, 0, 0, "");
        line(64, 8, 0, 4, 3, 1, 0, "R11");

        // R7: single-line vertical pulse
        keep = 1;
        plain(2, 64, 8, 0);
        line(64, 56, 0, 50, 2, 0, 1, "R7");
        line(64, 8, 0, 30, 2, 0, 0, "R7");

        // R9: outlier period of 100 must not move the threshold
        plain(3, 64, 8, 0);
        line(100, 8, 0, -1, 0, 0, 0, "");
        line(64, 36, 0, 40, 2, 0, 1, "R9");
        line(64, 8, 0, -1, 0, 0, 0, "");
        line(64, 8, 0, 30, 2, 0, 0, "R9");

        // R8: new rate of 40, threshold becomes 20
        plain(4, 40, 5, 0);
        line(40, 24, 0, 22, 2, 0, 1, "R8");
        line(40, 5, 0, -1, 0, 0, 0, "");
        line(40, 5, 0, 20, 2, 0, 0, "R8");

        // R4: separate vertical sync wins, composite broad pulses ignored
        vsp = 1; vsync = 0;
        plain(2, 64, 8, 0);
        line(64, 56, 0, 50, 2, 0, 0, "R4");
        vsync = 1;
        line(64, 8, 0, 30, 2, 0, 1, "R4");
        vsync = 0;
        line(64, 8, 0, 30, 2, 0, 0, "R4");

        repeat (5) @(negedge clk);
        if (sb.size() != 0) begin
            total++; fails++;
            $display("FAIL scoreboard: left=%0d expected 0", sb.size());
        end
        done = 1;
        finish_run();
    end

endmodule